// File: doc/BRIEF.md
# Five-Stage Tile Pipeline Scheduler

This controller sequences feature-map tiles through a shared layer engine. Each tile passes five stages in a fixed order: fetch from external memory, 3x3 depthwise compute, 1x1 pointwise compute, 2x2 max-pool (or pass-through), and store to external memory. The scheduler gives each stage a one-cycle start pulse and waits for that stage's done pulse. It lets different stages work on different tiles at the same time, so fetch and store overlap computation.

Every stage boundary uses a two-half (ping-pong) buffer. The half for tile t is t mod 2. A stage may not run more than one tile ahead of the stage that drains its output buffer. A layer is described by a tile count and a pool enable, both latched when the layer starts. Layers run one after another: a new layer is accepted only after the store stage has finished the last tile of the previous one. Status outputs show, for each stage, whether it is busy and which tile index it holds.

Top module: `tile_sched`

## Requirements
- R1: After reset there are no start pulses, no stage is busy, every stage tile index is 0, and `layer_busy` and `layer_done` are low.
- R2: Each stage takes tiles 0..N-1 in ascending order. Stage s (s>0) starts tile t only after stage s-1 has finished tile t. No stage starts a tile index of N or more.
- R3: A start pulse for a stage comes only while a layer runs and the stage is idle. The stage is then busy until its done pulse, holding one tile at most.
- R4: `st_bufsel[s]` equals bit 0 of the stage's tile index. Stage s (s<4) starts tile t only when stage s+1 has finished tile t-2, so no buffer half is overwritten before it is drained.
- R5: `layer_done` pulses for one cycle, in the cycle after the store stage (index 4) reports done on the last tile. In that same cycle `layer_busy` falls.
- R6: A layer start with a tile count of 0 produces a `layer_done` pulse in the next cycle, with no start pulse and with `layer_busy` staying low.
- R7: `layer_go` while a layer is running is ignored. The tile count and pool enable latched at the layer's start stay in force.
- R8: While a layer runs, `pool_bypass` is the inverse of the latched pool enable. The pool stage (index 3) is still started for every tile.
- R9: A done pulse on a stage that is not busy changes neither its busy flag nor its tile index.
- R10: `st_busy[s]` shows whether stage s holds a tile. `st_tile` slice s (TW bits, stage 0 in the least significant slice) is the held tile index while the stage is busy, and otherwise the count of tiles it has finished in the current layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| layer_go | input | 1 | Layer start request, accepted only when idle |
| layer_tiles | input | TW | Tile count of the layer |
| layer_pool_en | input | 1 | 1 = pool stage does 2x2 max, 0 = pass-through |
| layer_busy | output | 1 | A layer is in progress |
| layer_done | output | 1 | One-cycle layer completion pulse |
| pool_bypass | output | 1 | Pool stage must pass data through |
| st_start | output | 5 | Per-stage start pulse; bit 0 fetch, 1 depthwise, 2 pointwise, 3 pool, 4 store |
| st_done | input | 5 | Per-stage done pulse, same bit order |
| st_bufsel | output | 5 | Buffer half for the tile the stage starts or holds |
| st_busy | output | 5 | Stage holds a tile |
| st_tile | output | 5*TW | Per-stage tile index / finished count |

## Verification
A wrong per-stage tile counter shows on `st_tile` and `st_bufsel` in the cycle after the faulty update. It is also caught at the next start pulse, when that start breaks the ordering check against the neighbour stages. A lost or extra busy flag shows on `st_busy` one cycle after the start or done that caused it. A mistake in layer completion shows on `layer_done` or `layer_busy` in the cycle after the final store done, or as a layer that never finishes. The sweep covers tile counts 0 to 5, both pool settings, several uneven stage latency sets, stray done pulses on idle stages, and a start request made in the middle of a layer.

// File: rtl/tile_sched.sv
module tile_sched #(
  parameter int TW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            layer_go,
  input  logic [TW-1:0]   layer_tiles,
  input  logic            layer_pool_en,
  output logic            layer_busy,
  output logic            layer_done,
  output logic            pool_bypass,
  output logic [4:0]      st_start,
  input  logic [4:0]      st_done,
  output logic [4:0]      st_bufsel,
  output logic [4:0]      st_busy,
  output logic [5*TW-1:0] st_tile
);
  localparam int NS = 5;

  logic          run, pool_q, done_q;
  logic [TW-1:0] ntiles;
  logic [TW-1:0] fin [NS];
  logic [NS-1:0] busy, go;
  logic          accept, last_wb;

  assign accept  = layer_go && !run;
  assign last_wb = run && busy[NS-1] && st_done[NS-1] &&
                   (({1'b0, fin[NS-1]} + 1'b1) == {1'b0, ntiles});

  for (genvar s = 0; s < NS; s++) begin : g_st
    logic up_ok, dn_ok;
    if (s == 0) begin : g_first
      assign up_ok = 1'b1;
    end else begin : g_mid
      assign up_ok = fin[s-1] > fin[s];
    end
    if (s == NS-1) begin : g_last
      assign dn_ok = 1'b1;
    end else begin : g_buf
      assign dn_ok = {1'b0, fin[s]} <= ({1'b0, fin[s+1]} + 1'b1);
    end
    assign go[s] = run && !busy[s] && (fin[s] < ntiles) && up_ok && dn_ok;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy[s] <= 1'b0;
        fin[s]  <= '0;
      end else if (accept) begin
        busy[s] <= 1'b0;
        fin[s]  <= '0;
      end else if (go[s]) begin
        busy[s] <= 1'b1;
      end else if (busy[s] && st_done[s]) begin
        busy[s] <= 1'b0;
        fin[s]  <= fin[s] + 1'b1;
      end
    end

    assign st_tile[s*TW +: TW] = fin[s];
    assign st_bufsel[s]        = fin[s][0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      pool_q <= 1'b0;
      done_q <= 1'b0;
      ntiles <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        ntiles <= layer_tiles;
        pool_q <= layer_pool_en;
        run    <= layer_tiles != '0;
        done_q <= layer_tiles == '0;
      end else if (last_wb) begin
        run    <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign st_start    = go;
  assign st_busy     = busy;
  assign layer_busy  = run;
  assign layer_done  = done_q;
  assign pool_bypass = !pool_q;
endmodule

module tile_sched_chk #(
  parameter int TW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            layer_go,
  input logic [TW-1:0]   layer_tiles,
  input logic            layer_busy,
  input logic            layer_done,
  input logic [4:0]      st_start,
  input logic [4:0]      st_done,
  input logic [4:0]      st_busy,
  input logic [5*TW-1:0] st_tile
);
  for (genvar s = 0; s < 5; s++) begin : g_c
    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_start[s] |=> st_busy[s]);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_busy[s] && !st_done[s]) |=> (st_busy[s] && $stable(st_tile[s*TW +: TW])));
    // R9
    stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_busy[s] && !st_start[s] && !(layer_go && !layer_busy)) |=>
        (!st_busy[s] && $stable(st_tile[s*TW +: TW])));
    if (s > 0) begin : g_up
      // R2
      order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_start[s] |-> (st_tile[(s-1)*TW +: TW] > st_tile[s*TW +: TW]));
    end
    if (s < 4) begin : g_dn
      // R4
      pingpong_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_start[s] |-> ({1'b0, st_tile[s*TW +: TW]} <= {1'b0, st_tile[(s+1)*TW +: TW]} + 1'b1));
    end
  end
  // R6
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (layer_go && !layer_busy && layer_tiles == '0) |=> (layer_done && !layer_busy && st_start == '0));
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    layer_done |-> (!layer_busy && st_busy == '0));
  // R3
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !layer_busy |-> st_start == '0);
endmodule

bind tile_sched tile_sched_chk #(.TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .layer_go(layer_go), .layer_tiles(layer_tiles),
  .layer_busy(layer_busy), .layer_done(layer_done), .st_start(st_start),
  .st_done(st_done), .st_busy(st_busy), .st_tile(st_tile)
);

// File: tb/tile_sched_tb_top.sv
module tile_sched_tb_top;
  localparam int TW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            layer_go = 1'b0;
  logic [TW-1:0]   layer_tiles = '0;
  logic            layer_pool_en = 1'b0;
  logic            layer_busy, layer_done, pool_bypass;
  logic [4:0]      st_start, st_bufsel, st_busy;
  logic [4:0]      st_done = '0;
  logic [5*TW-1:0] st_tile;

  always #2.5 clk = ~clk;

  tile_sched #(.TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .layer_go(layer_go), .layer_tiles(layer_tiles),
    .layer_pool_en(layer_pool_en), .layer_busy(layer_busy), .layer_done(layer_done),
    .pool_bypass(pool_bypass), .st_start(st_start), .st_done(st_done),
    .st_bufsel(st_bufsel), .st_busy(st_busy), .st_tile(st_tile)
  );

  int vectors = 0, fails = 0, cycles = 0;
  int lat [5];
  int rem [5];
  int fin_m [5];
  int fin_c [5];
  bit busy_m [5];
  bit run_m = 0, pend_wb = 0, pool_m = 0, inject = 0;
  int n_m = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  task automatic cyc();
    bit accept, exp_done, zero_go;
    @(negedge clk);
    cycles++;
    accept   = layer_go && !run_m;
    zero_go  = accept && (layer_tiles == '0);
    exp_done = pend_wb || zero_go;
    if (pend_wb) run_m = 0;
    pend_wb = 0;
    if (accept) begin
      for (int s = 0; s < 5; s++) begin fin_m[s] = 0; busy_m[s] = 0; end
      if (layer_tiles != '0) begin
        run_m = 1; n_m = int'(layer_tiles); pool_m = layer_pool_en;
      end
    end
    chk(layer_done == exp_done, zero_go ? "R6 layer_done" : "R5 layer_done",
        int'(layer_done), int'(exp_done));
    chk(layer_busy == run_m, "R5 layer_busy", int'(layer_busy), int'(run_m));
    if (run_m) chk(pool_bypass == !pool_m, "R8 pool_bypass", int'(pool_bypass), int'(!pool_m));
    for (int s = 0; s < 5; s++) fin_c[s] = fin_m[s];
    for (int s = 0; s < 5; s++) begin
      chk(st_busy[s] == busy_m[s], "R10 st_busy", int'(st_busy[s]), int'(busy_m[s]));
      chk(int'(st_tile[s*TW +: TW]) == fin_c[s], "R10/R9 st_tile",
          int'(st_tile[s*TW +: TW]), fin_c[s]);
      if (st_start[s]) begin
        chk(run_m, "R3 start while idle layer", 1, int'(run_m));
        chk(!busy_m[s], "R3 start while busy", 1, int'(busy_m[s]));
        chk(fin_c[s] < n_m, "R2 tile beyond count", fin_c[s], n_m);
        if (s > 0) chk(fin_c[s-1] > fin_c[s], "R2 upstream not finished", fin_c[s-1], fin_c[s] + 1);
        if (s < 4) chk(fin_c[s] <= fin_c[s+1] + 1, "R4 buffer half not drained", fin_c[s+1], fin_c[s] - 1);
        chk(st_bufsel[s] == fin_c[s][0], "R4 st_bufsel", int'(st_bufsel[s]), fin_c[s] % 2);
        busy_m[s] = 1; rem[s] = lat[s]; st_done[s] = 1'b0;
      end else if (busy_m[s]) begin
        rem[s]--;
        if (rem[s] == 0) begin
          st_done[s] = 1'b1; busy_m[s] = 0; fin_m[s]++;
          if (s == 4 && fin_m[s] == n_m) pend_wb = 1;
        end else st_done[s] = 1'b0;
      end else begin
        st_done[s] = inject && ((cycles + s) % 3 == 0);
      end
    end
  endtask

  task automatic run_layer(input int n, input bit pen, input bit mid_go);
    int k;
    layer_tiles = n[TW-1:0]; layer_pool_en = pen; layer_go = 1'b1;
    cyc();
    layer_go = 1'b0;
    k = 0;
    while ((run_m || pend_wb) && k < 2000) begin
      if (mid_go && k == 4) begin
        layer_tiles = 1; layer_pool_en = !pen; layer_go = 1'b1;   // R7 ignored
      end
      cyc();
      layer_go = 1'b0;
      k++;
    end
    chk(k < 2000, "R5 layer never completed", k, 2000);
    cyc();
    chk(int'(st_tile[4*TW +: TW]) == n, "R7 store tiles finished", int'(st_tile[4*TW +: TW]), n);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 5; s++) begin lat[s] = 1; rem[s] = 0; fin_m[s] = 0; busy_m[s] = 0; end
    repeat (3) @(negedge clk);
    chk(st_start == '0 && st_busy == '0 && st_tile == '0 && !layer_busy && !layer_done,
        "R1 reset state", int'(st_busy), 0);
    rst_n = 1'b1;
    cyc();
    chk(st_start == '0 && !layer_busy, "R1 idle after reset", int'(st_start), 0);
    for (int ls = 0; ls < 4; ls++) begin
      for (int s = 0; s < 5; s++) begin
        case (ls)
          0: lat[s] = 1;
          1: lat[s] = 1 + (s * 3) % 4;
          2: lat[s] = (s % 2) ? 4 : 1;
          default: lat[s] = 5 - s;
        endcase
      end
      for (int n = 0; n <= 5; n++)
        for (int p = 0; p < 2; p++) begin
          inject = (n + p + ls) % 2;
          run_layer(n, p[0], 0);
        end
    end
    inject = 1;
    run_layer(4, 1'b1, 1);
    run_layer(5, 1'b0, 1);
    run_layer(15, 1'b1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule